// File: doc/BRIEF.md
# Dual-Column Readout Shift Register

This block buffers a full frame of conversion results for output. It stores 64 result words and arranges them as two columns that run side by side. Words with an even index sit in one column and words with an odd index sit in the other. On every rising edge of the shift clock, each column moves one place toward the output. The output bus therefore always shows one even/odd pair of words.

Loading is synchronous to the shift clock. The parallel result bus is copied in only when a shift-clock edge arrives while the load request is high. The first pair then sits at the output. The remaining pairs follow, one per edge, until the last pair appears 31 edges later.

A test mode checks the shift path without the converter. While test mode is on, parallel loading is blocked. Each column then takes its incoming tail word from its own serial pin, with the pin's level copied across every bit of the word. A pattern applied this way reaches the output 32 edges after it enters.

Top module: `readout_shift_reg`

## Requirements
- R1: While the active-low asynchronous reset is low, every stored word is zero and `pair_out` reads all zeros.
- R2: A rising clock edge with `load_req` high and `test_en` low copies all 64 words from `load_data`. Word k occupies bits [k*W +: W]. After that edge, `pair_out` shows word 0 and word 1.
- R3: A rising clock edge that does not load moves every pair one position toward the output. After a load followed by 31 such edges, `pair_out` shows words 62 and 63.
- R4: A change on `load_data` while `load_req` is low has no effect on stored contents. `load_data` is sampled only at an edge where `load_req` is high.
- R5: While `test_en` is high, `load_req` is ignored and the edge shifts instead.
- R6: In test mode, the tail odd word (index 63) takes `{W{ser_odd}}` and the tail even word (index 62) takes `{W{ser_even}}` on each edge. A value applied at the serial inputs therefore appears at `pair_out` after 32 edges.
- R7: Outside test mode, a shift fills the tail pair with zeros. Once 32 shifts follow a load, `pair_out` is zero.
- R8: The even word of the pair occupies `pair_out[2W-1:W]` and the odd word occupies `pair_out[W-1:0]`. Each word's most significant bit sits at the higher index, so `pair_out[2W-1]`, the leftmost bit, is the most significant bit of the even word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; every rising edge loads or shifts |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | Parallel load request, taken at a rising edge |
| test_en | input | 1 | Test mode: blocks loading, feeds tails from serial pins |
| ser_odd | input | 1 | Serial test bit for the odd-word column |
| ser_even | input | 1 | Serial test bit for the even-word column |
| load_data | input | NWORDS*W | Parallel result words, word k at [k*W +: W] |
| pair_out | output | 2*W | Even word (upper half) and odd word (lower half) at the head |

## Verification
The bench builds the block with its defaults: W = 4 and 64 words, which makes a 256-bit parallel bus and an 8-bit output. At this size, a full drain of 32 pairs fits within a short directed run, and a random word value covers all 16 codes. The bench therefore exercises the load-to-last-pair timing, the 32-edge serial latency and the zero-fill flush exactly as specified. Random phases mix loads, test mode and serial bits, so that test-mode load requests and loads arriving mid-drain are hit many times.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
   typedef enum logic {
      COL_EVEN = 1'b0,
      COL_ODD  = 1'b1
   } col_e;

   // Column that holds a given word index
   function automatic col_e col_of(input int idx);
      return (idx % 2 == 1) ? COL_ODD : COL_EVEN;
   endfunction
endpackage

// File: rtl/rsr_column.sv
module rsr_column #(
   parameter int W     = 4,
   parameter int DEPTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [DEPTH*W-1:0]   load_data_i,
   input  logic [W-1:0]         tail_i,
   output logic [W-1:0]         head_o,
   output logic [W-1:0]         next_o,
   output logic [W-1:0]         tail_o
);
   localparam int LAST = DEPTH - 1;

   generate
      if (W < 1) begin : g_bad_w
         $error("rsr_column: W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("rsr_column: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
      end else if (load_i) begin
         for (int s = 0; s < DEPTH; s++) stage_q[s] <= load_data_i[s*W +: W];
      end else begin
         for (int s = 0; s < LAST; s++) stage_q[s] <= stage_q[s+1];
         stage_q[LAST] <= tail_i;
      end
   end

   assign head_o = stage_q[0];
   assign next_o = stage_q[1];
   assign tail_o = stage_q[LAST];

   // R3
   shift_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> head_o == $past(next_o));
endmodule

// File: rtl/readout_shift_reg.sv
module readout_shift_reg #(
   parameter int W      = 4,
   parameter int NWORDS = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_req,
   input  logic                 test_en,
   input  logic                 ser_odd,
   input  logic                 ser_even,
   input  logic [NWORDS*W-1:0]  load_data,
   output logic [2*W-1:0]       pair_out
);
   import rsr_pkg::*;

   localparam int NPAIR = NWORDS / 2;

   generate
      if (NWORDS % 2 != 0 || NWORDS < 4) begin : g_bad_n
         $error("readout_shift_reg: NWORDS must be even and at least 4");
      end
   endgenerate

   logic          do_load;
   logic [W-1:0]  head_w [2];
   logic [W-1:0]  next_w [2];
   logic [W-1:0]  tail_w [2];
   logic [W-1:0]  fill_w [2];

   assign do_load = load_req && !test_en;

   generate
      for (genvar c = 0; c < 2; c++) begin : g_col
         logic [NPAIR*W-1:0] col_data;
         logic               ser_bit;

         // Column c gathers word indices 2k+c
         for (genvar k = 0; k < NPAIR; k++) begin : g_map
            assign col_data[k*W +: W] = load_data[(2*k + c)*W +: W];
         end

         if (col_of(c) == COL_ODD) begin : g_odd
            assign ser_bit = ser_odd;
         end else begin : g_even
            assign ser_bit = ser_even;
         end

         assign fill_w[c] = test_en ? {W{ser_bit}} : '0;

         rsr_column #(.W(W), .DEPTH(NPAIR)) i_col (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (do_load),
            .load_data_i (col_data),
            .tail_i      (fill_w[c]),
            .head_o      (head_w[c]),
            .next_o      (next_w[c]),
            .tail_o      (tail_w[c])
         );
      end
   endgenerate

   assign pair_out = {head_w[0], head_w[1]};

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         rst_clear_chk: assert (pair_out == '0);
      end
   end

   // R2
   load_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !test_en) |=>
         pair_out == {$past(load_data[W-1:0]), $past(load_data[2*W-1:W])});

   // R5
   test_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |=> pair_out == $past({next_w[0], next_w[1]}));

   // R6
   ser_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |=> (tail_w[0] == {W{$past(ser_even)}}) &&
                  (tail_w[1] == {W{$past(ser_odd)}}));

   // R7
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_en && !load_req) |=> (tail_w[0] == '0) && (tail_w[1] == '0));
endmodule

// File: tb/test_readout_shift_reg.sv
module test_readout_shift_reg;
   localparam int W      = 4;
   localparam int NWORDS = 64;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                load_req = 1'b0;
   logic                test_en = 1'b0;
   logic                ser_odd = 1'b0;
   logic                ser_even = 1'b0;
   logic [NWORDS*W-1:0] load_data = '0;
   logic [2*W-1:0]      pair_out;

   int vectors = 0;
   int errors  = 0;
   logic [W-1:0] mdl [NWORDS];

   readout_shift_reg #(.W(W), .NWORDS(NWORDS)) i_readout_shift_reg (
      .clk(clk), .rst_n(rst_n), .load_req(load_req), .test_en(test_en),
      .ser_odd(ser_odd), .ser_even(ser_even), .load_data(load_data),
      .pair_out(pair_out)
   );

   always #10 clk = ~clk;

   // R8: even word on the upper half
   function automatic logic [2*W-1:0] exp_pair();
      return {mdl[0], mdl[1]};
   endfunction

   task automatic check(input logic [2*W-1:0] exp, input string req);
      vectors++;
      if (pair_out !== exp) begin
         errors++;
         $display("FAIL %s: pair_out=%h expected=%h", req, pair_out, exp);
      end
   endtask

   task automatic model_edge(input logic ld, input logic tst, input logic a,
                             input logic b, input logic [NWORDS*W-1:0] d);
      if (ld && !tst) begin
         for (int k = 0; k < NWORDS; k++) mdl[k] = d[k*W +: W];
      end else begin
         for (int k = 0; k < NWORDS-2; k++) mdl[k] = mdl[k+2];
         mdl[NWORDS-2] = tst ? {W{b}} : '0;
         mdl[NWORDS-1] = tst ? {W{a}} : '0;
      end
   endtask

   // Drive at negedge, take one edge, check at the next negedge
   task automatic step(input logic ld, input logic tst, input logic a,
                       input logic b, input string req);
      load_req = ld; test_en = tst; ser_odd = a; ser_even = b;
      @(posedge clk);
      model_edge(ld, tst, a, b, load_data);
      @(negedge clk);
      check(exp_pair(), req);
   endtask

   task automatic rand_data();
      for (int k = 0; k < NWORDS; k++) load_data[k*W +: W] = W'($urandom);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] pat_o, pat_e;
      void'($urandom(32'h5eed_0042));
      for (int k = 0; k < NWORDS; k++) mdl[k] = '0;
      @(negedge clk);
      check('0, "R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 load, then R3 drain to words 62/63, then R7 zero fill
      rand_data();
      step(1, 0, 0, 0, "R2 load pair 0/1");
      check({load_data[0 +: W], load_data[W +: W]}, "R2 R8 words 0/1 mapping");
      for (int i = 0; i < 31; i++) step(0, 0, 0, 0, "R3 shift");
      check({load_data[62*W +: W], load_data[63*W +: W]}, "R3 words 62/63");
      step(0, 0, 0, 0, "R7 flush");
      check('0, "R7 zero after 32 shifts");

      // R4: data changes without load_req leave contents alone
      rand_data();
      step(1, 0, 0, 0, "R2 reload");
      for (int i = 0; i < 5; i++) begin
         rand_data();
         step(0, 0, 0, 0, "R4 data ignored without load");
      end

      // R5: load blocked in test mode
      rand_data();
      for (int i = 0; i < 4; i++) step(1, 1, 1, 0, "R5 load inhibited");

      // R6: serial pattern reaches output after 32 edges
      pat_o = $urandom; pat_e = $urandom;
      for (int i = 0; i < 32; i++) step(0, 1, pat_o[i], pat_e[i], "R6 inject");
      check({{W{pat_e[0]}}, {W{pat_o[0]}}}, "R6 first pattern bit at output");
      for (int i = 1; i < 32; i++) begin
         step(0, 0, 0, 0, "R6 drain");
         check({{W{pat_e[i]}}, {W{pat_o[i]}}}, "R6 pattern order");
      end

      // R1 asynchronous reset mid-run
      rand_data();
      step(1, 0, 0, 0, "R2 load before reset");
      #3 rst_n = 1'b0;
      #2;
      for (int k = 0; k < NWORDS; k++) mdl[k] = '0;
      check('0, "R1 async clear");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) step(0, 0, 0, 0, "R1 all words cleared");

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic ld, tst;
         if ($urandom_range(0, 7) == 0) rand_data();
         ld  = ($urandom_range(0, 9) == 0);
         tst = ($urandom_range(0, 3) == 0);
         step(ld, tst, 1'($urandom), 1'($urandom), "R3 R5 R6 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule